// File: doc/BRIEF.md
# Flash Read Port with Byte/Word Width and Identification Readout

This block is the read side of a flash memory's bus interface. It watches the chip-enable, output-enable and write-enable strobes and decides when the data bus is driven. It turns the array's 16-bit read word into the value placed on that bus. In word mode all sixteen data lines carry the word. In byte mode only the low eight lines are driven, lines 14..8 float, and data line 15 becomes an input: it serves as the lowest byte-address bit and selects which half of the array word is returned.

When the identification flag is set, the array word is ignored and fixed codes are returned instead. Low address bits select the code: the manufacturer code, the device code, or a single protect bit for the sector that the upper address bits select. The device code and the sector layout depend on whether the part has its small boot sectors at the top or at the bottom of the address space. A parameter chooses between the two.

Output data is registered once per clock while a read is in progress. The bus enable is withdrawn combinationally as soon as the read condition ends.

Top module: `flash_read_port`

## Requirements
- R1: A read is in progress while `ce_n`=0, `oe_n`=0 and `we_n`=1. The data-bus enable turns on in the clock cycle after the first rising edge that samples a read, and only while the read is still in progress.
- R2: The same cycle that `ce_n` rises, `oe_n` rises or `we_n` falls, every bit of `dq_oe` is 0.
- R3: In word mode (`word_mode`=1) with the identification flag clear, `dq_out` equals `arr_data` as sampled at the previous rising edge, and all 16 bits of `dq_oe` are 1.
- R4: In byte mode (`word_mode`=0) only `dq_oe[7:0]` are 1. `dq_out[15:8]` is 0. `dq_out[7:0]` is `arr_data[7:0]` when `dq15_addr`=0 and `arr_data[15:8]` when `dq15_addr`=1.
- R5: In identification mode with `addr[6]`=0, `addr[1]`=0 and `addr[0]`=0, the output is 0x52, zero-extended to the bus width.
- R6: In identification mode with `addr[6]`=0, `addr[1]`=0 and `addr[0]`=1, the output is the device code. For a top-boot part it is 0x22B9 in word mode and 0x00B9 in byte mode. For a bottom-boot part it is 0x22BA in word mode and 0x00BA in byte mode.
- R7: In identification mode with `addr[6]`=0, `addr[1]`=1 and `addr[0]`=0, bit 0 of the output is `prot_mask[s]` and all other bits are 0. For a top-boot part, s is set by the word address: below 0x38000, s = address>>15; 0x38000–0x3BFFF gives 7; 0x3C000–0x3CFFF gives 8; 0x3D000–0x3DFFF gives 9; 0x3E000 and above gives 10.
- R8: For a bottom-boot part, the sector index used by the protect query is set by the word address: 0x00000–0x01FFF gives 0; 0x02000–0x02FFF gives 1; 0x03000–0x03FFF gives 2; 0x04000–0x07FFF gives 3; 0x08000 and above gives (address>>15)+3.
- R9: In identification mode, an output of 0 is returned when `addr[6]`=1, or when `addr[1]`=1 and `addr[0]`=1. In identification mode `arr_data` has no effect on the output.
- R10: While `rst_n` is low, and in the first cycle after it rises, `dq_oe` is 0 whatever the strobes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| word_mode | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| addr | input | 18 | Word address |
| dq15_addr | input | 1 | Data line 15 used as the lowest byte-address bit in byte mode |
| arr_data | input | 16 | Word read from the array |
| id_mode | input | 1 | Identification readout active |
| prot_mask | input | 11 | Protect bit of each sector |
| dq_out | output | 16 | Data driven onto the bus |
| dq_oe | output | 16 | Per-line drive enable |

## Verification
Every data result becomes visible one clock after the inputs that produce it. The bench therefore sets inputs on a falling edge, lets one rising edge pass, and compares `dq_out` and `dq_oe` on the following falling edge. The release of the bus has no register in its path. For that check the bench changes one strobe on a falling edge and samples one time unit later, with no clock edge in between. Two instances, one top-boot and one bottom-boot, receive the same stimulus. Both are compared against a model whose sector mapping is written as address ranges rather than bit patterns.

// File: rtl/flash_read_port.sv
module flash_read_port #(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter int NSECT = 11,
  parameter bit TOP_BOOT = 1'b1,
  parameter logic [7:0] MFR_CODE = 8'h52,
  parameter logic [7:0] DEV_UPPER = 8'h22,
  parameter logic [7:0] DEV_TOP = 8'hB9,
  parameter logic [7:0] DEV_BOT = 8'hBA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          word_mode,
  input  logic [AW-1:0] addr,
  input  logic          dq15_addr,
  input  logic [DW-1:0] arr_data,
  input  logic          id_mode,
  input  logic [NSECT-1:0] prot_mask,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] dq_oe
);
  localparam int BW = DW / 2;
  localparam int SW = $clog2(NSECT);
  localparam logic [7:0] DEV_LOW = TOP_BOOT ? DEV_TOP : DEV_BOT;

  logic          rd, live;
  logic          valid_q, wide_q;
  logic [DW-1:0] data_q, nxt, id_val;
  logic [BW-1:0] half;
  logic [5:0]    hi;
  logic [SW-1:0] sec;
  logic          unused_addr_bits;

  assign rd = !ce_n && !oe_n && we_n;
  assign hi = addr[AW-1 -: 6];
  assign unused_addr_bits = ^{addr[AW-7:7], addr[5:2]};

  always_comb begin
    if (TOP_BOOT) begin
      if (hi[5:3] != 3'b111)     sec = SW'(hi[5:3]);
      else if (!hi[2])           sec = SW'(7);
      else if (hi[1:0] == 2'b00) sec = SW'(8);
      else if (hi[1:0] == 2'b01) sec = SW'(9);
      else                       sec = SW'(10);
    end else begin
      if (hi[5:3] != 3'b000)     sec = SW'(hi[5:3]) + SW'(3);
      else if (hi[2])            sec = SW'(3);
      else if (!hi[1])           sec = SW'(0);
      else if (!hi[0])           sec = SW'(1);
      else                       sec = SW'(2);
    end
  end

  always_comb begin
    id_val = '0;
    if (!addr[6]) begin
      case ({addr[1], addr[0]})
        2'b00: id_val = DW'(MFR_CODE);
        2'b01: id_val = word_mode ? DW'({DEV_UPPER, DEV_LOW}) : DW'(DEV_LOW);
        2'b10: id_val = DW'(prot_mask[sec]);
        default: id_val = '0;
      endcase
    end
  end

  assign half = dq15_addr ? arr_data[DW-1:BW] : arr_data[BW-1:0];
  assign nxt  = id_mode ? id_val : (word_mode ? arr_data : DW'(half));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      wide_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd;
      if (rd) begin
        data_q <= nxt;
        wide_q <= word_mode;
      end
    end
  end

  assign live   = valid_q && rd;
  assign dq_out = data_q;
  assign dq_oe  = {{BW{live && wide_q}}, {BW{live}}};
endmodule

// File: rtl/flash_read_port_chk.sv
module flash_read_port_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          word_mode,
  input logic          id_mode,
  input logic          a6,
  input logic          a1,
  input logic          a0,
  input logic          dq15_addr,
  input logic [DW-1:0] arr_data,
  input logic [DW-1:0] dq_out,
  input logic [DW-1:0] dq_oe
);
  localparam int BW = DW / 2;

  // R1
  enable_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[0] |-> ($past(!ce_n && !oe_n && we_n) && !ce_n && !oe_n && we_n));

  // R2
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |-> (dq_oe == '0));

  // R3
  word_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe[0] && $past(word_mode) && !$past(id_mode)) |-> (dq_out == $past(arr_data)));

  // R4
  byte_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe[0] && !$past(word_mode)) |-> (dq_oe[DW-1:BW] == '0));

  // R4
  byte_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe[0] && !$past(word_mode) && !$past(id_mode)) |->
      (dq_out == DW'($past(dq15_addr) ? $past(arr_data[DW-1:BW]) : $past(arr_data[BW-1:0]))));

  // R5
  mfr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe[0] && $past(id_mode && !a6 && !a1 && !a0)) |-> (dq_out == DW'(8'h52)));

  // R7
  prot_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe[0] && $past(id_mode && !a6 && a1 && !a0)) |-> (dq_out[DW-1:1] == '0));

  // R9
  id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe[0] && $past(id_mode && (a6 || (a1 && a0)))) |-> (dq_out == '0));
endmodule

bind flash_read_port flash_read_port_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .word_mode(word_mode), .id_mode(id_mode),
  .a6(addr[6]), .a1(addr[1]), .a0(addr[0]),
  .dq15_addr(dq15_addr), .arr_data(arr_data),
  .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/flash_read_port_test.sv
module flash_read_port_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic word_mode = 1'b1, dq15_addr = 1'b0, id_mode = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] arr_data = '0;
  logic [10:0] prot_mask = '0;
  logic [15:0] out_t, oe_t, out_b, oe_b;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_read_port #(.TOP_BOOT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .word_mode(word_mode), .addr(addr), .dq15_addr(dq15_addr),
    .arr_data(arr_data), .id_mode(id_mode), .prot_mask(prot_mask),
    .dq_out(out_t), .dq_oe(oe_t));

  flash_read_port #(.TOP_BOOT(1'b0)) uut_bot (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .word_mode(word_mode), .addr(addr), .dq15_addr(dq15_addr),
    .arr_data(arr_data), .id_mode(id_mode), .prot_mask(prot_mask),
    .dq_out(out_b), .dq_oe(oe_b));

  function automatic int sect_of(bit top, logic [17:0] a);
    if (top) begin
      if (a < 18'h38000) return int'(a >> 15);
      if (a < 18'h3C000) return 7;
      if (a < 18'h3D000) return 8;
      if (a < 18'h3E000) return 9;
      return 10;
    end
    if (a < 18'h02000) return 0;
    if (a < 18'h03000) return 1;
    if (a < 18'h04000) return 2;
    if (a < 18'h08000) return 3;
    return int'(a >> 15) + 3;
  endfunction

  function automatic logic [15:0] model(bit top);
    if (id_mode) begin
      if (addr[6]) return 16'h0000;
      case (addr[1:0])
        2'd0: return 16'h0052;
        2'd1: return word_mode ? (top ? 16'h22B9 : 16'h22BA) : (top ? 16'h00B9 : 16'h00BA);
        2'd2: return {15'b0, prot_mask[sect_of(top, addr)]};
        default: return 16'h0000;
      endcase
    end
    if (word_mode) return arr_data;
    return {8'h00, dq15_addr ? arr_data[15:8] : arr_data[7:0]};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic do_read(string req);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk({req, " top data"}, out_t, model(1'b1));
    chk({req, " bot data"}, out_b, model(1'b0));
    chk({req, " top oe"}, oe_t, word_mode ? 16'hFFFF : 16'h00FF);
    chk({req, " bot oe"}, oe_b, word_mode ? 16'hFFFF : 16'h00FF);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 oe in reset", oe_t, 16'h0000);
    rst_n = 1'b1;
    #1 chk("R10 oe first cycle after reset", oe_t, 16'h0000);

    // R3 word array reads
    word_mode = 1'b1; id_mode = 1'b0; arr_data = 16'hA55A; do_read("R3 word");
    arr_data = 16'h1234; do_read("R3 word change");

    // R1 enable requires a prior read cycle
    @(negedge clk); oe_n = 1'b1;
    #1 chk("R2 oe_n rise", oe_t | oe_b, 16'h0000);
    @(negedge clk); oe_n = 1'b0;
    #1 chk("R1 no enable before edge", oe_t, 16'h0000);
    @(posedge clk); @(negedge clk);
    chk("R1 enable after edge", oe_t, 16'hFFFF);
    ce_n = 1'b1;
    #1 chk("R2 ce_n rise", oe_t | oe_b, 16'h0000);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R2 we_n low", oe_t | oe_b, 16'h0000);

    // R4 byte mode, both halves
    word_mode = 1'b0; arr_data = 16'hC3E7; dq15_addr = 1'b0; do_read("R4 byte low");
    dq15_addr = 1'b1; do_read("R4 byte high");

    // R5 R6 R9 identification codes
    id_mode = 1'b1; arr_data = 16'hFFFF; addr = 18'h00000;
    word_mode = 1'b1; do_read("R5 mfr word");
    word_mode = 1'b0; do_read("R5 mfr byte");
    addr = 18'h00001; word_mode = 1'b1; do_read("R6 dev word");
    word_mode = 1'b0; do_read("R6 dev byte");
    addr = 18'h00003; do_read("R9 a1a0 both");
    addr = 18'h00040; word_mode = 1'b1; do_read("R9 a6 high");

    // R7 R8 protect queries across sector boundaries
    prot_mask = 11'b101_0101_0101;
    for (int i = 0; i < 20; i++) begin
      logic [17:0] edges [20] = '{18'h00000, 18'h01FFF, 18'h02000, 18'h02FFF, 18'h03000,
        18'h03FFF, 18'h04000, 18'h07FFF, 18'h08000, 18'h37FFF, 18'h38000, 18'h3BFFF,
        18'h3C000, 18'h3CFFF, 18'h3D000, 18'h3DFFF, 18'h3E000, 18'h3FFFF, 18'h10000, 18'h28000};
      addr = {edges[i][17:2], 2'b10};
      word_mode = i[0];
      do_read("R7 R8 protect");
    end
    prot_mask = ~prot_mask;
    for (int s = 0; s < 8; s++) begin
      addr = {3'(s), 15'h0002};
      do_read("R7 R8 protect inverted");
    end

    // random mix
    void'($urandom(32'd2024));
    for (int n = 0; n < 300; n++) begin
      addr = 18'($urandom);
      if (n % 3 == 0) addr[6] = 1'b0;
      arr_data = 16'($urandom);
      prot_mask = 11'($urandom);
      word_mode = 1'($urandom);
      dq15_addr = 1'($urandom);
      id_mode = ($urandom % 3) == 0;
      do_read("R3 R4 R6 R7 R8 R9 random");
      if (n % 10 == 0) begin
        @(negedge clk); oe_n = 1'b1;
        #1 chk("R2 random release", oe_t | oe_b, 16'h0000);
      end
    end

    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1 chk("R10 reset again", oe_t | oe_b, 16'h0000);
    finish_run();
  end
endmodule